// File: doc/BRIEF.md
# Serial host register command decoder

This block sits between the byte layer of a two-wire serial host link and a 10-bit on-chip register space. The bit-level bus engine hands it received bytes together with start and stop indications, and asks it for bytes to send back during reads. The block reads each transaction as an instruction byte, then a low address byte, then data. It turns the data into register writes or reads, one at a time or as bursts that step through consecutive addresses.

The register bus is shared with an on-chip microcontroller. A slot arbiter alternates ownership every cycle and hands an idle owner's slot to the other side, so each side is granted within two cycles of asking. The block keeps no registers of its own. Reads and writes happen on the shared bus, and the register file answers read data in the same cycle.

Top module: `shr_cmd_decoder`

## Requirements
- R1: Out of reset no strobe, acknowledge or reply is active. Bytes that arrive before the first start indication are ignored.
- R2: After a start, the first byte is the instruction. Its bits 7:4 must be 1000 and its bits 3:2 select the kind: 00 single write, 01 burst write, 10 single read, 11 burst read. Its bits 1:0 become register address bits 9:8, and the next byte gives address bits 7:0.
- R3: A single write stores the first data byte at the addressed register. Any further data bytes in that transaction cause no write.
- R4: A burst write stores each data byte at the next 10-bit address. The step carries from bit 7 into bit 8 (0x0FF to 0x100) and wraps from 0x3FF to 0x000.
- R5: In a single read, every byte request is answered with one tx_valid pulse within six cycles, carrying the addressed register. The address is not stepped.
- R6: In a burst read, successive byte requests return successive registers, with the same 10-bit step as R4.
- R7: Addresses with bits 9:8 = 11 are out of range. A write there produces no reg_wr strobe and a read there returns 0xFF. Bursts keep stepping through such addresses.
- R8: An instruction byte whose bits 7:4 are not 1000 makes the rest of the transaction cause no access.
- R9: A stop sends the parser back to idle, and later bytes are ignored until a start. A repeated start begins a new instruction.
- R10: Bus ownership alternates every cycle. A requester alone on the bus is granted in the cycle it asks, and a contended request is granted in the following cycle.
- R11: A microcontroller access is served in the cycle mcu_ack is high. Its address and data drive the bus in that cycle, and mcu_rdata carries the register value.
- R12: At most one requester owns the bus in a cycle, and reg_wr and reg_rd are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle pulse: a received byte is on rx_byte |
| rx_byte | input | 8 | Received byte |
| rx_start | input | 1 | One-cycle pulse: start or repeated start seen |
| rx_stop | input | 1 | One-cycle pulse: stop seen |
| tx_req | input | 1 | One-cycle pulse: the engine needs a byte to send |
| tx_valid | output | 1 | One-cycle pulse: tx_byte holds the reply |
| tx_byte | output | 8 | Byte to send to the host |
| reg_addr | output | 10 | Register bus address |
| reg_wdata | output | 8 | Register bus write data |
| reg_rdata | input | 8 | Register bus read data, valid in the strobe cycle |
| reg_wr | output | 1 | Write strobe |
| reg_rd | output | 1 | Read strobe |
| mcu_req | input | 1 | Microcontroller request, held until acknowledged |
| mcu_we | input | 1 | Microcontroller access is a write |
| mcu_addr | input | 10 | Microcontroller register address |
| mcu_wdata | input | 8 | Microcontroller write data |
| mcu_ack | output | 1 | Microcontroller access served this cycle |
| mcu_rdata | output | 8 | Read data returned to the microcontroller |

## Verification
A table of single writes, each followed by a read-back, covers all four values of the instruction's high address bits. A correct result shows that bits 1:0 reach the right 256-register page and that the out-of-range page is blocked. Burst writes started at 0x0FE and at 0x3FE separate a correct 10-bit step from one that stops at eight bits or fails to wrap. A burst read compared against repeated single reads at the same start separates stepping from holding the address. Sequences broken by a stop, by a repeated start, or by an unknown opcode show whether stale parser state leaks into later accesses. A host burst run alongside back-to-back microcontroller writes shows whether either side is starved or loses an access.

// File: rtl/shr_pkg.sv
package shr_pkg;
  localparam int SHR_AW = 10;
  localparam int SHR_DW = 8;
  localparam int SHR_HW = SHR_AW - 8;
  localparam logic [3:0] SHR_OP_TAG = 4'b1000;

  typedef enum logic [2:0] {
    SHR_PS_IDLE, SHR_PS_INSTR, SHR_PS_ADDR, SHR_PS_WDATA, SHR_PS_RDATA, SHR_PS_SKIP
  } shr_pstate_t;

  typedef enum logic [1:0] {
    SHR_WR_ONE = 2'b00, SHR_WR_BURST = 2'b01, SHR_RD_ONE = 2'b10, SHR_RD_BURST = 2'b11
  } shr_kind_t;

  function automatic logic shr_op_known(input logic [7:0] b);
    return b[7:4] == SHR_OP_TAG;
  endfunction

  function automatic shr_kind_t shr_kind_of(input logic [7:0] b);
    return shr_kind_t'(b[3:2]);
  endfunction

  function automatic logic shr_is_read(input shr_kind_t k);
    return (k == SHR_RD_ONE) || (k == SHR_RD_BURST);
  endfunction

  function automatic logic shr_is_burst(input shr_kind_t k);
    return (k == SHR_WR_BURST) || (k == SHR_RD_BURST);
  endfunction

  function automatic logic [SHR_AW-1:0] shr_step(input logic [SHR_AW-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic shr_in_range(input logic [SHR_AW-1:0] a);
    return a[SHR_AW-1:8] != {SHR_HW{1'b1}};
  endfunction
endpackage

// File: rtl/shr_slot_arbiter.sv
module shr_slot_arbiter #(
  parameter bit HOST_FIRST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic host_req,
  input  logic mcu_req,
  output logic host_gnt,
  output logic mcu_gnt
);
  logic slot_mcu_q;
  localparam logic SLOT_INIT = ~HOST_FIRST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot_mcu_q <= SLOT_INIT;
    else        slot_mcu_q <= ~slot_mcu_q;
  end

  assign host_gnt = host_req && (!slot_mcu_q || !mcu_req);
  assign mcu_gnt  = mcu_req  && ( slot_mcu_q || !host_req);
endmodule

// File: rtl/shr_bus_mux.sv
module shr_bus_mux
  import shr_pkg::*;
(
  input  logic              host_gnt,
  input  logic              host_we,
  input  logic [SHR_AW-1:0] host_addr,
  input  logic [SHR_DW-1:0] host_wdata,
  input  logic              mcu_gnt,
  input  logic              mcu_we,
  input  logic [SHR_AW-1:0] mcu_addr,
  input  logic [SHR_DW-1:0] mcu_wdata,
  output logic [SHR_AW-1:0] reg_addr,
  output logic [SHR_DW-1:0] reg_wdata,
  output logic              reg_wr,
  output logic              reg_rd
);
  always_comb begin
    reg_addr  = host_gnt ? host_addr  : mcu_addr;
    reg_wdata = host_gnt ? host_wdata : mcu_wdata;
    reg_wr    = (host_gnt && host_we)  || (mcu_gnt && mcu_we);
    reg_rd    = (host_gnt && !host_we) || (mcu_gnt && !mcu_we);
  end
endmodule

// File: rtl/shr_parser.sv
module shr_parser
  import shr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_start,
  input  logic              rx_stop,
  input  logic              tx_req,
  output logic              tx_valid,
  output logic [SHR_DW-1:0] tx_byte,
  output logic              host_req,
  output logic              host_we,
  output logic [SHR_AW-1:0] host_addr,
  output logic [SHR_DW-1:0] host_wdata,
  input  logic              host_gnt,
  input  logic [SHR_DW-1:0] reg_rdata,
  output logic              parser_idle,
  output logic              burst_inc,
  output logic [SHR_AW-1:0] cur_addr
);
  shr_pstate_t       state_q;
  shr_kind_t         kind_q;
  logic [SHR_AW-1:0] addr_q, req_addr_q;
  logic [SHR_DW-1:0] wdata_q, tx_byte_q;
  logic              req_q, we_q, tx_valid_q;

  logic quiet, wr_accept, rd_accept, accept, acc_live, acc_drop;

  assign quiet     = !rx_stop && !rx_start;
  assign wr_accept = quiet && rx_valid && (state_q == SHR_PS_WDATA);
  assign rd_accept = quiet && tx_req   && (state_q == SHR_PS_RDATA);
  assign accept    = wr_accept || rd_accept;
  assign acc_live  = accept && shr_in_range(addr_q);
  assign acc_drop  = accept && !shr_in_range(addr_q);
  assign burst_inc = accept && shr_is_burst(kind_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SHR_PS_IDLE;
      kind_q     <= SHR_WR_ONE;
      addr_q     <= '0;
      req_addr_q <= '0;
      wdata_q    <= '0;
      req_q      <= 1'b0;
      we_q       <= 1'b0;
      tx_valid_q <= 1'b0;
      tx_byte_q  <= '0;
    end else begin
      tx_valid_q <= 1'b0;
      if (host_gnt) begin
        req_q <= 1'b0;
        if (!we_q) begin
          tx_valid_q <= 1'b1;
          tx_byte_q  <= reg_rdata;
        end
      end
      if (acc_live) begin
        req_q      <= 1'b1;
        we_q       <= wr_accept;
        req_addr_q <= addr_q;
        wdata_q    <= rx_byte;
      end
      if (acc_drop && rd_accept) begin
        tx_valid_q <= 1'b1;
        tx_byte_q  <= '1;
      end
      if (burst_inc) addr_q <= shr_step(addr_q);

      if (rx_stop) begin
        state_q <= SHR_PS_IDLE;
      end else if (rx_start) begin
        state_q <= SHR_PS_INSTR;
      end else if (rx_valid) begin
        case (state_q)
          SHR_PS_INSTR: begin
            if (shr_op_known(rx_byte)) begin
              kind_q                <= shr_kind_of(rx_byte);
              addr_q[SHR_AW-1:8]    <= rx_byte[SHR_HW-1:0];
              state_q               <= SHR_PS_ADDR;
            end else begin
              state_q <= SHR_PS_SKIP;
            end
          end
          SHR_PS_ADDR: begin
            addr_q[7:0] <= rx_byte;
            state_q     <= shr_is_read(kind_q) ? SHR_PS_RDATA : SHR_PS_WDATA;
          end
          SHR_PS_WDATA: begin
            if (!shr_is_burst(kind_q)) state_q <= SHR_PS_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  assign tx_valid    = tx_valid_q;
  assign tx_byte     = tx_byte_q;
  assign host_req    = req_q;
  assign host_we     = we_q;
  assign host_addr   = req_addr_q;
  assign host_wdata  = wdata_q;
  assign parser_idle = (state_q == SHR_PS_IDLE);
  assign cur_addr    = addr_q;
endmodule

// File: rtl/shr_cmd_decoder.sv
module shr_cmd_decoder
  import shr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_start,
  input  logic              rx_stop,
  input  logic              tx_req,
  output logic              tx_valid,
  output logic [SHR_DW-1:0] tx_byte,
  output logic [SHR_AW-1:0] reg_addr,
  output logic [SHR_DW-1:0] reg_wdata,
  input  logic [SHR_DW-1:0] reg_rdata,
  output logic              reg_wr,
  output logic              reg_rd,
  input  logic              mcu_req,
  input  logic              mcu_we,
  input  logic [SHR_AW-1:0] mcu_addr,
  input  logic [SHR_DW-1:0] mcu_wdata,
  output logic              mcu_ack,
  output logic [SHR_DW-1:0] mcu_rdata
);
  logic              host_req, host_we, host_gnt, mcu_gnt;
  logic [SHR_AW-1:0] host_addr, cur_addr;
  logic [SHR_DW-1:0] host_wdata;
  logic              parser_idle, burst_inc;

  shr_parser u_parser (
    .clk(clk), .rst_n(rst_n),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_start(rx_start), .rx_stop(rx_stop),
    .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_gnt(host_gnt), .reg_rdata(reg_rdata),
    .parser_idle(parser_idle), .burst_inc(burst_inc), .cur_addr(cur_addr)
  );

  shr_slot_arbiter #(.HOST_FIRST(1'b1)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .mcu_req(mcu_req),
    .host_gnt(host_gnt), .mcu_gnt(mcu_gnt)
  );

  shr_bus_mux u_mux (
    .host_gnt(host_gnt), .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .mcu_gnt(mcu_gnt), .mcu_we(mcu_we), .mcu_addr(mcu_addr), .mcu_wdata(mcu_wdata),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd)
  );

  assign mcu_ack   = mcu_gnt;
  assign mcu_rdata = reg_rdata;
endmodule

// File: rtl/shr_cmd_decoder_chk.sv
module shr_cmd_decoder_chk
  import shr_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rx_stop,
  input logic              host_req,
  input logic              host_gnt,
  input logic              host_we,
  input logic [SHR_HW-1:0] host_addr_hi,
  input logic              mcu_req,
  input logic              mcu_gnt,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic              tx_valid,
  input logic              parser_idle,
  input logic              burst_inc,
  input logic [SHR_AW-1:0] cur_addr
);
  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_gnt && mcu_gnt)); // R12
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd)); // R12
  AST_HOST_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_gnt) |=> host_gnt); // R10
  AST_MCU_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_req && !mcu_gnt) |=> (mcu_gnt || !mcu_req)); // R10
  AST_LONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (mcu_req && !host_req) |-> mcu_gnt); // R10
  AST_RANGE_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_gnt && host_we) |-> (host_addr_hi != {SHR_HW{1'b1}})); // R7
  AST_READ_REPLY: assert property (@(posedge clk) disable iff (!rst_n)
    (host_gnt && !host_we) |=> tx_valid); // R5
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    burst_inc |=> (cur_addr == SHR_AW'($past(cur_addr) + 1'b1))); // R4
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stop |=> parser_idle); // R9
endmodule

bind shr_cmd_decoder shr_cmd_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_stop(rx_stop),
  .host_req(host_req), .host_gnt(host_gnt), .host_we(host_we),
  .host_addr_hi(host_addr[shr_pkg::SHR_AW-1:8]),
  .mcu_req(mcu_req), .mcu_gnt(mcu_gnt), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .tx_valid(tx_valid), .parser_idle(parser_idle), .burst_inc(burst_inc), .cur_addr(cur_addr)
);

// File: tb/shr_cmd_decoder_bench.sv
module shr_cmd_decoder_bench;
  localparam int CLK_P = 10;
  localparam int NVEC  = 6;
  // {hi[1:0], addr_lo[7:0], data[7:0]}
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd0, 8'h10, 8'h5A}, {2'd1, 8'h22, 8'hA5}, {2'd2, 8'hFF, 8'h3C},
    {2'd3, 8'h05, 8'h77}, {2'd0, 8'h00, 8'hC3}, {2'd2, 8'h80, 8'h01}
  };

  logic clk = 0, rst_n = 0;
  logic rx_valid = 0, rx_start = 0, rx_stop = 0, tx_req = 0;
  logic [7:0] rx_byte = 0;
  logic tx_valid; logic [7:0] tx_byte;
  logic [9:0] reg_addr; logic [7:0] reg_wdata, reg_rdata; logic reg_wr, reg_rd;
  logic mcu_req = 0, mcu_we = 0; logic [9:0] mcu_addr = 0; logic [7:0] mcu_wdata = 0;
  logic mcu_ack; logic [7:0] mcu_rdata;

  logic [7:0] rf [1024];
  int wr_count = 0;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  shr_cmd_decoder u_shr_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .rx_start(rx_start), .rx_stop(rx_stop), .tx_req(tx_req),
    .tx_valid(tx_valid), .tx_byte(tx_byte),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd),
    .mcu_req(mcu_req), .mcu_we(mcu_we), .mcu_addr(mcu_addr), .mcu_wdata(mcu_wdata),
    .mcu_ack(mcu_ack), .mcu_rdata(mcu_rdata)
  );

  assign reg_rdata = rf[reg_addr];
  always @(posedge clk) if (rst_n && reg_wr) begin
    rf[reg_addr] <= reg_wdata;
    wr_count <= wr_count + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk); rx_valid = 1; rx_byte = b;
    @(negedge clk); rx_valid = 0;
    repeat (3) @(negedge clk);
  endtask
  task automatic start_c; @(negedge clk); rx_start = 1; @(negedge clk); rx_start = 0; endtask
  task automatic stop_c;  @(negedge clk); rx_stop = 1;  @(negedge clk); rx_stop = 0;  endtask

  task automatic fetch(output logic [7:0] b, output bit got);
    got = 0; b = '0;
    @(negedge clk); tx_req = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); tx_req = 0;
      if (tx_valid && !got) begin got = 1; b = tx_byte; end
    end
  endtask

  task automatic host_read_one(input logic [1:0] hi, input logic [7:0] lo, output logic [7:0] b, output bit got);
    start_c; send(8'h88 | hi); send(lo); fetch(b, got); stop_c;
  endtask

  task automatic mcu_access(input bit we, input logic [9:0] a, input logic [7:0] d,
                            output logic [7:0] rd, output int waits);
    bit done = 0;
    waits = 0; rd = '0;
    @(negedge clk); mcu_req = 1; mcu_we = we; mcu_addr = a; mcu_wdata = d;
    for (int i = 0; i < 8; i++) begin
      if (!done) begin
        #(CLK_P/4);
        if (mcu_ack) begin
          rd = mcu_rdata; done = 1;
          @(posedge clk); #1 mcu_req = 0;
        end else begin
          waits++; @(negedge clk);
        end
      end
    end
    if (!done) begin mcu_req = 0; waits = 99; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b; bit got; int w0, waits, maxw;
    for (int i = 0; i < 1024; i++) rf[i] = 8'h00;
    repeat (2) @(negedge clk);
    chk(!reg_wr && !reg_rd && !tx_valid && !mcu_ack, "R1 reset outputs",
        {reg_wr, reg_rd, tx_valid, mcu_ack}, 0);
    rst_n = 1;
    // R1: bytes before any start
    w0 = wr_count; send(8'h80); send(8'h10); send(8'h99);
    chk(wr_count == w0, "R1 bytes before start", wr_count - w0, 0);

    // table: single write then single read back (R2, R3, R7)
    for (int v = 0; v < NVEC; v++) begin
      logic [1:0] hi; logic [7:0] lo, d, exp;
      {hi, lo, d} = VEC[v];
      exp = (hi == 2'd3) ? 8'hFF : d;
      w0 = wr_count;
      start_c; send(8'h80 | hi); send(lo); send(d); stop_c;
      chk(wr_count - w0 == ((hi == 2'd3) ? 0 : 1), "R7 write strobe count", wr_count - w0, (hi == 2'd3) ? 0 : 1);
      host_read_one(hi, lo, b, got);
      chk(got && b == exp, "R2 page select read back", b, exp);
    end

    // R3: extra bytes after a single write
    w0 = wr_count;
    start_c; send(8'h80); send(8'h40); send(8'h11); send(8'h22); send(8'h33); stop_c;
    chk(wr_count - w0 == 1, "R3 one write only", wr_count - w0, 1);
    host_read_one(2'd0, 8'h41, b, got);
    chk(got && b == 8'h00, "R3 next register untouched", b, 8'h00);
    host_read_one(2'd0, 8'h40, b, got);
    chk(got && b == 8'h11, "R3 first byte stored", b, 8'h11);

    // R4: burst write across the bit 7 -> bit 8 carry
    start_c; send(8'h84); send(8'hFE); send(8'hA1); send(8'hA2); send(8'hA3); stop_c;
    // R6: burst read back
    start_c; send(8'h8C); send(8'hFE);
    fetch(b, got); chk(got && b == 8'hA1, "R6 burst read 0x0FE", b, 8'hA1);
    fetch(b, got); chk(got && b == 8'hA2, "R6 burst read 0x0FF", b, 8'hA2);
    fetch(b, got); chk(got && b == 8'hA3, "R4 carry into 0x100", b, 8'hA3);
    stop_c;

    // R5: single read repeats the same register
    start_c; send(8'h88); send(8'hFE);
    for (int k = 0; k < 3; k++) begin
      fetch(b, got); chk(got && b == 8'hA1, "R5 single read holds address", b, 8'hA1);
    end
    stop_c;

    // R7 + R4: burst from 0x2FF runs into the invalid page, then wraps 0x3FF -> 0x000
    w0 = wr_count;
    start_c; send(8'h86); send(8'hFF); send(8'hB1); send(8'hB2); stop_c;
    chk(wr_count - w0 == 1, "R7 burst into invalid page", wr_count - w0, 1);
    w0 = wr_count;
    start_c; send(8'h87); send(8'hFE); send(8'hC1); send(8'hC2); send(8'hC3); stop_c;
    chk(wr_count - w0 == 1, "R7 invalid writes dropped", wr_count - w0, 1);
    host_read_one(2'd0, 8'h00, b, got);
    chk(got && b == 8'hC3, "R4 wrap to 0x000", b, 8'hC3);

    // R8: unknown opcode
    w0 = wr_count;
    start_c; send(8'h40); send(8'h50); send(8'h66); send(8'h67); stop_c;
    chk(wr_count == w0, "R8 unknown opcode ignored", wr_count - w0, 0);

    // R9: stop after the instruction, then stray bytes
    w0 = wr_count;
    start_c; send(8'h80); stop_c; send(8'h60); send(8'h77);
    chk(wr_count == w0, "R9 bytes after stop ignored", wr_count - w0, 0);
    // R9: repeated start restarts at the instruction byte
    start_c; send(8'h80); send(8'h61); start_c; send(8'h80); send(8'h62); send(8'h44); stop_c;
    chk(wr_count - w0 == 1, "R9 repeated start single write", wr_count - w0, 1);
    host_read_one(2'd0, 8'h62, b, got);
    chk(got && b == 8'h44, "R9 repeated start target", b, 8'h44);

    // R11 + R10: controller alone
    mcu_access(1'b1, 10'h123, 8'h5C, b, waits);
    chk(waits == 0, "R10 lone controller granted at once", waits, 0);
    mcu_access(1'b0, 10'h123, 8'h00, b, waits);
    chk(b == 8'h5C, "R11 controller read data", b, 8'h5C);

    // R10: contention between a host burst and controller writes
    maxw = 0;
    fork
      begin start_c; send(8'h84); send(8'h80);
        for (int k = 0; k < 4; k++) send(8'hD0 + 8'(k));
        stop_c; end
      begin
        for (int k = 0; k < 40; k++) begin
          mcu_access(1'b1, 10'h200 + 10'(k % 8), 8'hE0 + 8'(k), b, waits);
          if (waits > maxw) maxw = waits;
        end
      end
    join
    chk(maxw <= 1, "R10 controller wait bound", maxw, 1);
    for (int k = 0; k < 4; k++)
      chk(rf[10'h080 + 10'(k)] == 8'hD0 + 8'(k), "R10 host burst survived contention",
          rf[10'h080 + 10'(k)], 8'hD0 + 8'(k));
    mcu_access(1'b0, 10'h207, 8'h00, b, waits);
    chk(b == 8'hE0 + 8'd39, "R11 last controller write", b, 8'hE0 + 8'd39);
    chk(!(reg_wr && reg_rd), "R12 strobes exclusive at rest", {reg_wr, reg_rd}, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule